// File: doc/BRIEF.md
# Pipelined Majority-Logic Ripple Adder

This block adds two unsigned words and a carry-in. The carry ripples through a chain of one-bit slices, and each slice has exactly one register on the carry path. Every logic function is built from three-input majority gates and inverters. The carry of a slice is the majority of its two operand bits and its incoming carry. The sum bit is a second majority over three terms: the inverted carry-out, the majority of the operand bits with the incoming carry inverted, and the incoming carry itself.

The carry needs one cycle per bit position, so operand bit i is held back i cycles on entry. Each slice therefore meets its operands and its incoming carry in the same cycle. The sum path of a slice is three register stages deep. The sum bits leave the slices at staggered times, and a deskew array delays sum bit i by a further WIDTH-1-i cycles so that the whole word comes out aligned. The carry-out is delayed to match.

A new operand pair can be accepted on every clock. A valid flag travels alongside the data, so the output valid marks each cycle in which a complete result is present. The latency is WIDTH+2 cycles.

Top module: `mag_ripple_adder`

## Requirements
- R1: For every accepted word (in_valid high at a clock edge), out_sum equals (in_a + in_b + in_cin) mod 2^WIDTH and out_carry equals bit WIDTH of that full sum, treating all values as unsigned.
- R2: The result of a word accepted at clock edge e is presented with out_valid high after clock edge e+WIDTH+1, that is WIDTH+2 edges after the inputs were driven, and results keep the order of acceptance.
- R3: Words presented on consecutive clock edges with no gaps are all accepted, and each one produces its own correct result on consecutive output cycles.
- R4: A synchronous active-high rst drives out_valid, out_sum and out_carry to 0 on the following cycle and discards every word still in flight.
- R5: Carries travel the full width. All-ones plus 1 gives sum 0 with carry 1. All-ones plus all-ones plus carry-in 1 gives all-ones with carry 1. In the first slice, operand bits 0 that are both 1 always produce a carry one cycle later, and operand bits 0 that are both 0 never do.
- R6: A cycle in which in_valid is low produces no output: out_valid is low in the matching output cycle, and out_valid is never high unless a word is in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous active-high reset; clears the pipeline |
| in_valid | input | 1 | Marks in_a, in_b and in_cin as a word to add |
| in_a | input | WIDTH | First unsigned operand |
| in_b | input | WIDTH | Second unsigned operand |
| in_cin | input | 1 | Carry into bit 0 |
| out_valid | output | 1 | High when out_sum and out_carry hold a result |
| out_sum | output | WIDTH | Aligned sum word |
| out_carry | output | 1 | Carry out of the top bit |

## Verification
The bound checks assume that rst is held high from time zero through at least one clock edge, and that every input is at a known level at each edge after that. The in-flight bound relies on in_valid being a plain per-cycle flag with no handshake, so a word is counted as accepted on every edge where the flag is high. The stimulus holds every input at zero during reset, changes inputs only on the falling edge, and applies a second reset while words are in flight. It mixes unbroken streams with randomly placed idle cycles, so that both the stream limit and the bubble behaviour are exercised.

// File: rtl/mag_pkg.sv
package mag_pkg;

    // Three-input majority: the single logic primitive of the adder.
    function automatic logic maj3(input logic x, input logic y, input logic z);
        return (x & y) | (y & z) | (z & x);
    endfunction

    // Cycles from driving a word to seeing its aligned result.
    function automatic int unsigned adder_latency(input int unsigned width);
        return width + 2;
    endfunction

    // First register rank of a slice.
    typedef struct packed {
        logic carry;   // majority(a, b, c)
        logic part;    // majority(a, b, ~c)
        logic cfwd;    // incoming carry carried forward
    } slice_front_t;

endpackage

// File: rtl/mag_delay.sv
module mag_delay #(
    parameter int unsigned WIDTH = 1,
    parameter int unsigned DEPTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    generate
        if (DEPTH == 0) begin : g_wire
            logic unused_clk_rst;
            assign unused_clk_rst = clk ^ rst;
            assign q = d;
        end else begin : g_regs
            logic [WIDTH-1:0] stage [DEPTH];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int k = 0; k < int'(DEPTH); k++) stage[k] <= '0;
                end else begin
                    stage[0] <= d;
                    for (int k = 1; k < int'(DEPTH); k++) stage[k] <= stage[k-1];
                end
            end
            assign q = stage[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/mag_slice.sv
module mag_slice
    import mag_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic op_a,
    input  logic op_b,
    input  logic c_in,
    output logic c_out,
    output logic sum_out
);
    slice_front_t front_q;
    logic         sum_mid_q;
    logic         sum_out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            front_q   <= '0;
            sum_mid_q <= 1'b0;
            sum_out_q <= 1'b0;
        end else begin
            // Stage 1: the carry gate (the only gate on the carry path) and the sum helper gate.
            front_q.carry <= maj3(op_a, op_b, c_in);
            front_q.part  <= maj3(op_a, op_b, ~c_in);
            front_q.cfwd  <= c_in;
            // Stage 2: sum = maj(~carry_out, part, carry_in).
            sum_mid_q     <= maj3(~front_q.carry, front_q.part, front_q.cfwd);
            // Stage 3: output rank of the sum.
            sum_out_q     <= sum_mid_q;
        end
    end

    assign c_out   = front_q.carry;
    assign sum_out = sum_out_q;
endmodule

// File: rtl/mag_ripple_adder.sv
module mag_ripple_adder
    import mag_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    input  logic             in_cin,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_sum,
    output logic             out_carry
);
    localparam int unsigned LATENCY  = adder_latency(WIDTH);
    localparam int unsigned SUM_LAG  = 2;   // sum stages beyond the carry stage

    logic [WIDTH:0]   carry_link;
    logic [WIDTH-1:0] a_skewed;
    logic [WIDTH-1:0] b_skewed;
    logic [WIDTH-1:0] sum_raw;

    assign carry_link[0] = in_cin;

    generate
        for (genvar i = 0; i < int'(WIDTH); i++) begin : g_bit
            logic [1:0] pair_q;

            // Entry skew: bit i waits i cycles for its carry.
            mag_delay #(.WIDTH(2), .DEPTH(i)) u_skew (
                .clk (clk),
                .rst (rst),
                .d   ({in_a[i], in_b[i]}),
                .q   (pair_q)
            );
            assign a_skewed[i] = pair_q[1];
            assign b_skewed[i] = pair_q[0];

            mag_slice u_slice (
                .clk     (clk),
                .rst     (rst),
                .op_a    (a_skewed[i]),
                .op_b    (b_skewed[i]),
                .c_in    (carry_link[i]),
                .c_out   (carry_link[i+1]),
                .sum_out (sum_raw[i])
            );

            // Exit deskew: bit i waits for the top bit.
            mag_delay #(.WIDTH(1), .DEPTH(WIDTH-1-i)) u_deskew (
                .clk (clk),
                .rst (rst),
                .d   (sum_raw[i]),
                .q   (out_sum[i])
            );
        end
    endgenerate

    // Top carry is ready SUM_LAG cycles before the top sum bit.
    mag_delay #(.WIDTH(1), .DEPTH(SUM_LAG)) u_carry_align (
        .clk (clk),
        .rst (rst),
        .d   (carry_link[WIDTH]),
        .q   (out_carry)
    );

    mag_delay #(.WIDTH(1), .DEPTH(LATENCY)) u_valid_pipe (
        .clk (clk),
        .rst (rst),
        .d   (in_valid),
        .q   (out_valid)
    );
endmodule

// File: rtl/mag_ripple_adder_chk.sv
module mag_ripple_adder_chk #(
    parameter int unsigned WIDTH   = 8,
    parameter int unsigned LATENCY = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_a0,
    input logic             in_b0,
    input logic             carry0,
    input logic             out_valid,
    input logic [WIDTH-1:0] out_sum,
    input logic             out_carry
);
    localparam int unsigned CW = $clog2(LATENCY + 2) + 1;

    logic [CW-1:0] inflight;

    always_ff @(posedge clk) begin
        if (rst) inflight <= '0;
        else     inflight <= inflight + CW'(in_valid) - CW'(out_valid);
    end

    // R4
    reset_flush_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_valid && out_sum == '0 && !out_carry));

    // R5
    carry_gen_chk: assert property (@(posedge clk) disable iff (rst)
        (in_a0 && in_b0) |=> carry0);

    // R5
    carry_kill_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_a0 && !in_b0) |=> !carry0);

    // R2
    inflight_bound_chk: assert property (@(posedge clk) disable iff (rst)
        inflight <= CW'(LATENCY));

    // R6
    no_orphan_valid_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (inflight != '0));
endmodule

bind mag_ripple_adder mag_ripple_adder_chk #(.WIDTH(WIDTH), .LATENCY(LATENCY)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_a0     (in_a[0]),
    .in_b0     (in_b[0]),
    .carry0    (carry_link[1]),
    .out_valid (out_valid),
    .out_sum   (out_sum),
    .out_carry (out_carry)
);

// File: tb/mag_ripple_adder_test.sv
module mag_ripple_adder_test;
    localparam int unsigned W   = 8;
    localparam int unsigned LAT = W + 2;
    localparam logic [W-1:0] ONES = '1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_a = '0;
    logic [W-1:0] in_b = '0;
    logic         in_cin = 1'b0;
    logic         out_valid;
    logic [W-1:0] out_sum;
    logic         out_carry;

    mag_ripple_adder #(.WIDTH(W)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .in_cin(in_cin), .out_valid(out_valid), .out_sum(out_sum), .out_carry(out_carry)
    );

    always #10 clk = ~clk;   // 50 MHz

    int compared   = 0;
    int mismatched = 0;
    bit done       = 1'b0;
    bit just_reset = 1'b0;

    logic [W+1:0] exp_q [$];   // {valid, carry, sum}
    string        tag_q [$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_step();
        logic [W+1:0] e;
        string        t;
        if (just_reset) begin
            check(out_valid == 1'b0, "R4 valid", int'(out_valid), 0);
            check(out_sum == '0, "R4 sum", int'(out_sum), 0);
            check(out_carry == 1'b0, "R4 carry", int'(out_carry), 0);
            just_reset = 1'b0;
        end
        if (exp_q.size() == LAT) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (e[W+1]) begin
                check(out_valid == 1'b1, "R2 valid", int'(out_valid), 1);
                check(out_sum == e[W-1:0], {t, " sum"}, int'(out_sum), int'(e[W-1:0]));
                check(out_carry == e[W], {t, " carry"}, int'(out_carry), int'(e[W]));
            end else begin
                check(out_valid == 1'b0, "R6 bubble", int'(out_valid), 0);
            end
        end else begin
            check(out_valid == 1'b0, "R4 pipeline empty", int'(out_valid), 0);
        end
    endtask

    task automatic drive(input bit v, input logic [W-1:0] a, input logic [W-1:0] b,
                         input bit c, input string req);
        logic [W:0] full;
        @(negedge clk);
        compare_step();
        in_valid = v;
        in_a     = a;
        in_b     = b;
        in_cin   = c;
        full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
        exp_q.push_back({v, full});
        tag_q.push_back(req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; in_a = '0; in_b = '0; in_cin = 1'b0;
        @(negedge clk);
        @(negedge clk);
        exp_q.delete();
        tag_q.delete();
        rst = 1'b0;
        just_reset = 1'b1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin : stimulus
        do_reset();
        // R5 corner operands
        drive(1, '0,   '0,   0, "R1");
        drive(1, ONES, 8'd1, 0, "R5");
        drive(1, ONES, '0,   1, "R5");
        drive(1, ONES, ONES, 1, "R5");
        drive(1, ONES, ONES, 0, "R5");
        drive(1, 8'h55, 8'hAA, 1, "R5");
        drive(1, 8'h80, 8'h80, 0, "R1");
        drive(1, 8'h01, 8'h01, 0, "R5");
        // R3 back-to-back random stream
        for (int n = 0; n < 300; n++)
            drive(1, W'($urandom), W'($urandom), 1'($urandom), "R3");
        // R1/R6 random stream with bubbles
        for (int n = 0; n < 300; n++)
            drive(1'($urandom), W'($urandom), W'($urandom), 1'($urandom), "R1");
        // R4 reset while words are in flight
        for (int n = 0; n < 5; n++)
            drive(1, W'($urandom), W'($urandom), 1'($urandom), "R1");
        do_reset();
        for (int n = 0; n < int'(LAT) + 2; n++)
            drive(0, '0, '0, 0, "R6");
        for (int n = 0; n < 40; n++)
            drive(1, W'($urandom), W'($urandom), 1'($urandom), "R3");
        for (int n = 0; n < int'(LAT) + 2; n++)
            drive(0, '0, '0, 0, "R6");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule